// File: doc/BRIEF.md
# Burst Column Order Generator

This block turns one READ or WRITE command into the ordered list of column addresses for the data beats of its burst, one beat per clock. It takes the starting column, two command address bits (a chop select and an auto-precharge request) and the programmed burst settings: a 2-bit length mode and an ordering bit. The burst is either eight beats or a chopped burst of four.

The low three column bits are reordered. In sequential order, the start's nibble half is walked first, wrapping modulo four, and then the other half. In interleaved order, each beat's low bits are the start XOR the beat index. The upper column bits pass through unchanged. Every beat comes with a valid strobe, a last-beat flag, the captured auto-precharge request and an error flag for the reserved length code.

The settings and the command fields are captured when a command is accepted. A command arriving during the final beat of a burst is accepted, so bursts can run back to back with no gap. A command arriving during any other beat is dropped.

Top module: `burst_col_seq`

## Requirements
- R1: After reset `beat_valid`, `beat_last`, `beat_ap` and `mode_err` are low until a command is accepted.
- R2: A command accepted on a clock edge produces its first beat in the following cycle. The beats then follow on consecutive cycles with `beat_valid` high and no gaps.
- R3: `cfg_len_mode` 2'b00 gives 8 beats and 2'b10 gives 4 beats. In both cases `cmd_chop_sel` is ignored.
- R4: With `cfg_len_mode` 2'b01, `cmd_chop_sel` = 1 gives 8 beats and `cmd_chop_sel` = 0 gives 4 beats.
- R5: `cfg_len_mode` 2'b11 is reserved. It gives 8 beats with `mode_err` high on every beat of that burst. Any other mode holds `mode_err` low.
- R6: With `cfg_interleave` = 0 (sequential), beat i carries low column bits {s[2], (s[1:0]+i) mod 4} for i < 4, and {~s[2], (s[1:0]+i) mod 4} for i ≥ 4, where s is the start column.
- R7: With `cfg_interleave` = 1 (interleaved), beat i carries low column bits s[2:0] XOR i.
- R8: Column bits above bit 2 equal those of the start column on every beat.
- R9: `beat_last` is high only on the final beat: the 4th beat of a chopped burst or the 8th beat of a full burst.
- R10: `beat_ap` equals the `cmd_ap` value captured with the command and is held for every beat of the burst.
- R11: A command during a beat other than the last one is ignored. A command during the last beat starts a new burst whose first beat comes in the next cycle.
- R12: Changes to `cfg_len_mode` or `cfg_interleave` after a command is accepted do not affect that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | READ/WRITE command present |
| cmd_col | input | COL_W | Starting column address |
| cmd_ap | input | 1 | Auto-precharge request sampled with the command |
| cmd_chop_sel | input | 1 | Per-command length select: 1 = eight beats, 0 = four |
| cfg_len_mode | input | 2 | Burst length mode: 00 eight, 01 per command, 10 four, 11 reserved |
| cfg_interleave | input | 1 | Ordering: 0 sequential, 1 interleaved |
| beat_valid | output | 1 | A beat is presented this cycle |
| beat_col | output | COL_W | Column address of this beat |
| beat_last | output | 1 | Final beat of the burst |
| beat_ap | output | 1 | Captured auto-precharge request |
| mode_err | output | 1 | Burst was started with the reserved length mode |

## Verification
The vector table uses start columns in both nibble halves and at non-zero offsets inside each half. A sequential walk that carried into bit 2, or forgot to flip the half after four beats, would therefore give a visibly wrong column order. Chopped bursts in both orderings check that `beat_last` falls on the fourth beat rather than the eighth. The per-command mode is run with both values of the chop select, so a swapped polarity would show up as a wrong beat count. Directed tests change the settings right after a command is accepted, raise a command mid-burst and raise one on the last beat: a design that sampled the settings late, or let the mid-burst command through, would corrupt the running sequence, and one that stalled would open a gap between bursts.

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [COL_W-1:0] cmd_col,
  input  logic             cmd_ap,
  input  logic             cmd_chop_sel,
  input  logic [1:0]       cfg_len_mode,
  input  logic             cfg_interleave,
  output logic             beat_valid,
  output logic [COL_W-1:0] beat_col,
  output logic             beat_last,
  output logic             beat_ap,
  output logic             mode_err
);
  localparam int OFS_W = 3;
  localparam logic [OFS_W-1:0] FULL_END = OFS_W'(7);
  localparam logic [OFS_W-1:0] CHOP_END = OFS_W'(3);

  logic             active, chop_r, itlv_r, ap_r, err_r;
  logic [OFS_W-1:0] idx;
  logic [COL_W-1:0] start_r;
  logic             chop_next, last, accept;
  logic [OFS_W-1:0] low_seq, low_itl;

  always_comb begin
    case (cfg_len_mode)
      2'b01:   chop_next = ~cmd_chop_sel;
      2'b10:   chop_next = 1'b1;
      default: chop_next = 1'b0;
    endcase
  end

  assign last   = active && (idx == (chop_r ? CHOP_END : FULL_END));
  assign accept = cmd_valid && (!active || last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      chop_r  <= 1'b0;
      itlv_r  <= 1'b0;
      ap_r    <= 1'b0;
      err_r   <= 1'b0;
      idx     <= '0;
      start_r <= '0;
    end else if (accept) begin
      active  <= 1'b1;
      chop_r  <= chop_next;
      itlv_r  <= cfg_interleave;
      ap_r    <= cmd_ap;
      err_r   <= (cfg_len_mode == 2'b11);
      idx     <= '0;
      start_r <= cmd_col;
    end else if (active) begin
      if (last) begin
        active <= 1'b0;
        ap_r   <= 1'b0;
        err_r  <= 1'b0;
      end
      idx <= idx + 1'b1;
    end
  end

  assign low_seq = {start_r[2] ^ idx[2], start_r[1:0] + idx[1:0]};
  assign low_itl = start_r[OFS_W-1:0] ^ idx;

  assign beat_valid = active;
  assign beat_last  = last;
  assign beat_ap    = ap_r;
  assign mode_err   = err_r;
  assign beat_col   = {start_r[COL_W-1:OFS_W], itlv_r ? low_itl : low_seq};
endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             beat_valid,
  input logic [COL_W-1:0] beat_col,
  input logic             beat_last,
  input logic             beat_ap,
  input logic             mode_err
);
  // R9
  last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |-> beat_valid);
  // R2
  burst_no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_last |=> beat_valid);
  // R2
  start_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !beat_valid |=> beat_valid);
  // R10
  ap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_last |=> $stable(beat_ap));
  // R5
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_last |=> $stable(mode_err));
  // R8
  upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_last |=> $stable(beat_col[COL_W-1:3]));
  // R6
  low_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_last |=> beat_col[2:0] != $past(beat_col[2:0]));
  // R11
  idle_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last && !cmd_valid |=> !beat_valid);
  // R1
  idle_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_valid |-> !beat_ap && !mode_err);
endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .beat_valid(beat_valid),
  .beat_col(beat_col), .beat_last(beat_last), .beat_ap(beat_ap), .mode_err(mode_err)
);

// File: tb/burst_col_seq_test.sv
module burst_col_seq_test;
  localparam int COL_W = 10;

  typedef struct packed {
    logic [1:0]  mode;
    logic        itlv;
    logic        chop;
    logic        ap;
    logic [9:0]  col;
    logic [3:0]  len;
    logic        err;
    logic [31:0] seq;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{2'b00, 1'b0, 1'b0, 1'b0, 10'h000, 4'd8, 1'b0, 32'h76543210},
    '{2'b00, 1'b0, 1'b0, 1'b0, 10'h0AD, 4'd8, 1'b0, 32'h03214765},
    '{2'b00, 1'b1, 1'b0, 1'b0, 10'h0AD, 4'd8, 1'b0, 32'h23016745},
    '{2'b10, 1'b0, 1'b1, 1'b0, 10'h3FE, 4'd4, 1'b0, 32'h00005476},
    '{2'b01, 1'b1, 1'b0, 1'b0, 10'h123, 4'd4, 1'b0, 32'h00000123},
    '{2'b01, 1'b0, 1'b1, 1'b0, 10'h2A2, 4'd8, 1'b0, 32'h54761032},
    '{2'b11, 1'b1, 1'b0, 1'b1, 10'h1C7, 4'd8, 1'b1, 32'h01234567},
    '{2'b10, 1'b1, 1'b0, 1'b1, 10'h0F4, 4'd4, 1'b0, 32'h00007654},
    '{2'b01, 1'b1, 1'b1, 1'b0, 10'h206, 4'd8, 1'b0, 32'h10325476},
    '{2'b00, 1'b0, 1'b0, 1'b1, 10'h3FB, 4'd8, 1'b0, 32'h65472103}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ap = 1'b0, cmd_chop_sel = 1'b0, cfg_interleave = 1'b0;
  logic [COL_W-1:0] cmd_col = '0;
  logic [1:0] cfg_len_mode = 2'b00;
  logic beat_valid, beat_last, beat_ap, mode_err;
  logic [COL_W-1:0] beat_col;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_col(cmd_col),
    .cmd_ap(cmd_ap), .cmd_chop_sel(cmd_chop_sel), .cfg_len_mode(cfg_len_mode),
    .cfg_interleave(cfg_interleave), .beat_valid(beat_valid), .beat_col(beat_col),
    .beat_last(beat_last), .beat_ap(beat_ap), .mode_err(mode_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic issue(input vec_t v);
    cmd_valid = 1'b1; cmd_col = v.col; cmd_ap = v.ap;
    cmd_chop_sel = v.chop; cfg_len_mode = v.mode; cfg_interleave = v.itlv;
  endtask

  // Walks one burst starting at the current negedge (beat 0 visible)
  task automatic expect_burst(input vec_t v);
    for (int i = 0; i < int'(v.len); i++) begin
      check("R2 valid", 32'(beat_valid), 32'd1);
      check("R6/R7 low col", 32'(beat_col[2:0]), 32'(v.seq[4*i +: 3]));
      check("R8 upper col", 32'(beat_col[COL_W-1:3]), 32'(v.col[COL_W-1:3]));
      check("R9 last", 32'(beat_last), 32'(i == int'(v.len) - 1));
      check("R10 ap", 32'(beat_ap), 32'(v.ap));
      check("R5 err", 32'(mode_err), 32'(v.err));
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid", 32'(beat_valid), 32'd0);
    check("R1 last", 32'(beat_last), 32'd0);
    check("R1 ap", 32'(beat_ap), 32'd0);
    check("R1 err", 32'(mode_err), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", 32'(beat_valid), 32'd0);

    // Table walk: R3 R4 R5 R6 R7; settings scrambled after accept for R12
    for (int k = 0; k < NV; k++) begin
      issue(VEC[k]);
      @(negedge clk);
      cmd_valid = 1'b0;
      cfg_len_mode = ~VEC[k].mode;
      cfg_interleave = ~VEC[k].itlv;
      cmd_chop_sel = ~VEC[k].chop;
      expect_burst(VEC[k]);
      check("R9 idle after burst", 32'(beat_valid), 32'd0);
      check("R10 ap cleared", 32'(beat_ap), 32'd0);
    end

    // R11: command mid-burst ignored
    issue(VEC[0]);
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i == 2) begin
        cmd_valid = 1'b1; cmd_col = 10'h3FF; cfg_len_mode = 2'b10; cfg_interleave = 1'b1;
      end else begin
        cmd_valid = 1'b0;
      end
      check("R11 mid-burst low col", 32'(beat_col[2:0]), 32'(VEC[0].seq[4*i +: 3]));
      check("R11 mid-burst upper", 32'(beat_col[COL_W-1:3]), 32'd0);
      check("R11 mid-burst last", 32'(beat_last), 32'(i == 7));
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    check("R11 idle after ignored cmd", 32'(beat_valid), 32'd0);

    // R11: command on last beat chains with no gap
    issue(VEC[3]);
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int i = 0; i < 3; i++) @(negedge clk);
    check("R11 on last beat", 32'(beat_last), 32'd1);
    issue(VEC[6]);
    @(negedge clk);
    cmd_valid = 1'b0;
    v = VEC[6];
    expect_burst(v);
    check("R11 idle after chain", 32'(beat_valid), 32'd0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule